// File: doc/BRIEF.md
# Clock Calibration Counter

This block measures the frequency of one slow or on-chip clock against another clock. Firmware picks a clock to measure (the target), a clock to measure it with (the reference) and a window length in target-clock cycles, then sets a start bit. While the window is open, the block counts cycles of the reference into a result register. When the last target cycle of the window arrives, the start bit drops back to zero, the result is frozen, and an interrupt event is recorded. The ratio of result to window length gives the target period in reference cycles, which firmware uses to trim timers that run from the target clock.

Every clock is presented to the block as a one-cycle enable pulse on the fabric clock, so the whole unit lives in one clock domain. Five target sources and six reference sources arrive as tick vectors, indexed by their select code. Configuration is written as one word: target select, reference select and window length together. The interrupt has an enable flag, a write-one clear strobe, and a status output that is active low: it reads 0 while an event is pending.

Top module: `clkcal_unit`

## Requirements
- R1: The target select code picks bit `tgt_tick[code]`: 0 slow RC low-power oscillator, 1 fast 32 MHz RC oscillator, 2 32 kHz crystal, 3 trimmable RC oscillator, 4 general RC oscillator. Pulses on any other target bit do not advance the window.
- R2: The reference select code picks bit `ref_tick[code]`: 0 divided system clock, 1 slow RC low-power oscillator, 2 fast 32 MHz RC oscillator, 3 32 kHz crystal, 4 general RC oscillator, 5 external input. Pulses on any other reference bit are not counted.
- R3: A `go` pulse while idle, with a stored window N > 0, makes `busy` read 1 from the next cycle. `busy` returns to 0 in the cycle after the clock edge that takes the Nth selected target pulse.
- R4: Starting a measurement clears the result. The result then equals the number of cycles in which `busy` was 1 and the selected reference ticked, including the cycle of the final target pulse. It holds that value until the next start.
- R5: The result saturates at all ones (2^RES_W - 1) and never wraps.
- R6: While `busy` is 1, configuration writes (`cfg_we`) and further `go` pulses are ignored. The measurement in progress keeps its target, reference and window.
- R7: A `go` while idle with a stored window of 0 leaves `busy` at 0. In the next cycle the result is 0 and an interrupt event is pending.
- R8: Every completion sets the pending flag, and `irq_stat_n` reads 0 while the flag is set. An `irq_clr` pulse clears it. If a completion and a clear land on the same edge, the completion wins.
- R9: `irq` is 1 exactly when an event is pending and the enable flag is set. The enable flag is written through `irq_en_we`/`irq_en_wdata` and resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tgt_tick | input | TGT_N (5) | Target clock enable pulses, one per source |
| ref_tick | input | REF_N (6) | Reference clock enable pulses, one per source |
| cfg_we | input | 1 | Write the configuration word (ignored while busy) |
| cfg_tgt_sel | input | SEL_W (3) | Target select code |
| cfg_ref_sel | input | SEL_W (3) | Reference select code |
| cfg_window | input | WIN_W (16) | Window length in target cycles |
| go | input | 1 | Set the start bit |
| irq_en_we | input | 1 | Write the interrupt enable flag |
| irq_en_wdata | input | 1 | New interrupt enable value |
| irq_clr | input | 1 | Write-one clear of the pending event |
| busy | output | 1 | Start bit read-back: 1 while measuring |
| result | output | RES_W (32) | Reference cycle count |
| irq_stat_n | output | 1 | Interrupt status, 0 while pending |
| irq | output | 1 | Interrupt request line |

## Verification
The bench attacks the ends of the window. The final target pulse must close the window and still have its reference tick counted; an off-by-one counter would stop one target cycle early or late, or drop the last reference cycle. A second instance with a 6-bit result overruns its counter, so a design that wrapped would report a small count. Writes and `go` pulses injected in the middle of a run would shorten the window or restart the count if they were not blocked. A zero-length window must complete without hanging. A clear that lands on the same edge as a completion must leave the event pending rather than losing it.

// File: rtl/clkcal_pkg.sv
package clkcal_pkg;

   localparam int unsigned TGT_COUNT = 5;
   localparam int unsigned REF_COUNT = 6;
   localparam int unsigned CODE_W    = 3;

   typedef enum logic [CODE_W-1:0] {
      TGT_RC_LP   = 3'd0,
      TGT_RC_FAST = 3'd1,
      TGT_XT_SLOW = 3'd2,
      TGT_RC_TRIM = 3'd3,
      TGT_RC_GEN  = 3'd4
   } tgt_code_e;

   typedef enum logic [CODE_W-1:0] {
      REF_DIV     = 3'd0,
      REF_RC_LP   = 3'd1,
      REF_RC_FAST = 3'd2,
      REF_XT_SLOW = 3'd3,
      REF_RC_GEN  = 3'd4,
      REF_EXT     = 3'd5
   } ref_code_e;

endpackage

// File: rtl/clkcal_tick_mux.sv
module clkcal_tick_mux #(
   parameter int unsigned N     = 5,
   parameter int unsigned SEL_W = 3
) (
   input  logic [SEL_W-1:0] sel,
   input  logic [N-1:0]     ticks,
   output logic             hit
);
   logic [N-1:0] match;

   generate
      for (genvar i = 0; i < N; i++) begin : g_src
         assign match[i] = ticks[i] && (sel == SEL_W'(i));
      end
   endgenerate

   assign hit = |match;
endmodule

// File: rtl/clkcal_window.sv
module clkcal_window #(
   parameter int unsigned WIN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [WIN_W-1:0] length,
   input  logic             active,
   input  logic             hit,
   output logic             last
);
   logic [WIN_W-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain <= '0;
      end else if (load) begin
         remain <= length;
      end else if (active && hit && remain != '0) begin
         remain <= remain - 1'b1;
      end
   end

   assign last = active && hit && (remain == WIN_W'(1));
endmodule

// File: rtl/clkcal_accum.sv
module clkcal_accum #(
   parameter int unsigned RES_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             inc,
   output logic [RES_W-1:0] value
);
   localparam logic [RES_W-1:0] TOP = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         value <= '0;
      end else if (clear) begin
         value <= '0;
      end else if (inc && value != TOP) begin
         value <= value + 1'b1;
      end
   end
endmodule

// File: rtl/clkcal_irq.sv
module clkcal_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic event_set,
   input  logic clr,
   input  logic en_we,
   input  logic en_wdata,
   output logic pending,
   output logic req
);
   logic en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending <= 1'b0;
         en_q    <= 1'b0;
      end else begin
         if (event_set) begin
            pending <= 1'b1;
         end else if (clr) begin
            pending <= 1'b0;
         end
         if (en_we) begin
            en_q <= en_wdata;
         end
      end
   end

   assign req = pending && en_q;
endmodule

// File: rtl/clkcal_unit.sv
module clkcal_unit
   import clkcal_pkg::*;
#(
   parameter int unsigned WIN_W = 16,
   parameter int unsigned RES_W = 32,
   parameter int unsigned TGT_N = TGT_COUNT,
   parameter int unsigned REF_N = REF_COUNT,
   parameter int unsigned SEL_W = CODE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TGT_N-1:0] tgt_tick,
   input  logic [REF_N-1:0] ref_tick,
   input  logic             cfg_we,
   input  logic [SEL_W-1:0] cfg_tgt_sel,
   input  logic [SEL_W-1:0] cfg_ref_sel,
   input  logic [WIN_W-1:0] cfg_window,
   input  logic             go,
   input  logic             irq_en_we,
   input  logic             irq_en_wdata,
   input  logic             irq_clr,
   output logic             busy,
   output logic [RES_W-1:0] result,
   output logic             irq_stat_n,
   output logic             irq
);
   localparam int unsigned MAX_SRC = (TGT_N > REF_N) ? TGT_N : REF_N;

   generate
      if (RES_W < 2) begin : g_bad_res
         $error("clkcal_unit: RES_W must be at least 2");
      end
      if (WIN_W < 1) begin : g_bad_win
         $error("clkcal_unit: WIN_W must be at least 1");
      end
      if ((1 << SEL_W) < MAX_SRC) begin : g_bad_sel
         $error("clkcal_unit: SEL_W too narrow for the source count");
      end
   endgenerate

   logic [SEL_W-1:0] sel_tgt_q;
   logic [SEL_W-1:0] sel_ref_q;
   logic [WIN_W-1:0] win_q;
   logic             busy_q;
   logic             tgt_hit;
   logic             ref_hit;
   logic             win_last;
   logic             start_ok;
   logic             zero_win;
   logic             done_evt;
   logic             pending;

   assign start_ok = go && !busy_q;
   assign zero_win = (win_q == '0);
   assign done_evt = win_last || (start_ok && zero_win);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_tgt_q <= SEL_W'(TGT_RC_LP);
         sel_ref_q <= SEL_W'(REF_DIV);
         win_q     <= '0;
      end else if (cfg_we && !busy_q) begin
         sel_tgt_q <= cfg_tgt_sel;
         sel_ref_q <= cfg_ref_sel;
         win_q     <= cfg_window;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
      end else if (start_ok && !zero_win) begin
         busy_q <= 1'b1;
      end else if (win_last) begin
         busy_q <= 1'b0;
      end
   end

   clkcal_tick_mux #(.N(TGT_N), .SEL_W(SEL_W)) u_tgt_mux (
      .sel   (sel_tgt_q),
      .ticks (tgt_tick),
      .hit   (tgt_hit)
   );

   clkcal_tick_mux #(.N(REF_N), .SEL_W(SEL_W)) u_ref_mux (
      .sel   (sel_ref_q),
      .ticks (ref_tick),
      .hit   (ref_hit)
   );

   clkcal_window #(.WIN_W(WIN_W)) u_window (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (start_ok),
      .length (win_q),
      .active (busy_q),
      .hit    (tgt_hit),
      .last   (win_last)
   );

   clkcal_accum #(.RES_W(RES_W)) u_accum (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (start_ok),
      .inc   (busy_q && ref_hit),
      .value (result)
   );

   clkcal_irq u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .event_set(done_evt),
      .clr      (irq_clr),
      .en_we    (irq_en_we),
      .en_wdata (irq_en_wdata),
      .pending  (pending),
      .req      (irq)
   );

   assign busy       = busy_q;
   assign irq_stat_n = !pending;
endmodule

// File: rtl/clkcal_unit_chk.sv
module clkcal_unit_chk #(
   parameter int unsigned WIN_W = 16,
   parameter int unsigned RES_W = 32,
   parameter int unsigned SEL_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             go,
   input logic             irq_clr,
   input logic             busy,
   input logic [RES_W-1:0] result,
   input logic             irq_stat_n,
   input logic             tgt_hit,
   input logic [SEL_W-1:0] sel_tgt_q,
   input logic [SEL_W-1:0] sel_ref_q,
   input logic [WIN_W-1:0] win_q
);
   // R3: the window closes only on a selected target pulse
   a_r3_close_on_target: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(tgt_hit));

   // R5: the count never decreases while a run is open
   a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy) |-> (result >= $past(result)));

   // R6: configuration holds while busy
   a_r6_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy) |-> ($stable(sel_tgt_q) && $stable(sel_ref_q) && $stable(win_q)));

   // R7: zero window completes at once with a zero count
   a_r7_zero_window: assert property (@(posedge clk) disable iff (!rst_n)
      (go && !busy && win_q == '0) |=> (!busy && result == '0 && !irq_stat_n));

   // R8: a completed run leaves an event pending
   a_r8_done_pending: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> !irq_stat_n);

   // R8: a clear with no competing completion empties the flag
   a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(irq_clr) && !$past(busy) && !$past(go)) |-> irq_stat_n);
endmodule

bind clkcal_unit clkcal_unit_chk #(.WIN_W(WIN_W), .RES_W(RES_W), .SEL_W(SEL_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .go         (go),
   .irq_clr    (irq_clr),
   .busy       (busy),
   .result     (result),
   .irq_stat_n (irq_stat_n),
   .tgt_hit    (tgt_hit),
   .sel_tgt_q  (sel_tgt_q),
   .sel_ref_q  (sel_ref_q),
   .win_q      (win_q)
);

// File: tb/clkcal_unit_test.sv
`timescale 1ns/1ps
module clkcal_unit_test;
   localparam int unsigned SAT_W = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  tgt_tick = '0;
   logic [5:0]  ref_tick = '0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_tgt_sel = '0;
   logic [2:0]  cfg_ref_sel = '0;
   logic [15:0] cfg_window = '0;
   logic        go = 1'b0;
   logic        irq_en_we = 1'b0;
   logic        irq_en_wdata = 1'b0;
   logic        irq_clr = 1'b0;
   logic        busy, irq_stat_n, irq;
   logic [31:0] result;
   logic        s_busy, s_stat_n, s_irq;
   logic [SAT_W-1:0] s_result;

   int checks = 0;
   int errors = 0;
   bit ended = 0;

   always #2.5 clk = ~clk;

   clkcal_unit uut (
      .clk(clk), .rst_n(rst_n), .tgt_tick(tgt_tick), .ref_tick(ref_tick),
      .cfg_we(cfg_we), .cfg_tgt_sel(cfg_tgt_sel), .cfg_ref_sel(cfg_ref_sel),
      .cfg_window(cfg_window), .go(go), .irq_en_we(irq_en_we),
      .irq_en_wdata(irq_en_wdata), .irq_clr(irq_clr), .busy(busy),
      .result(result), .irq_stat_n(irq_stat_n), .irq(irq)
   );

   clkcal_unit #(.RES_W(SAT_W)) uut_sat (
      .clk(clk), .rst_n(rst_n), .tgt_tick(tgt_tick), .ref_tick(ref_tick),
      .cfg_we(cfg_we), .cfg_tgt_sel(cfg_tgt_sel), .cfg_ref_sel(cfg_ref_sel),
      .cfg_window(cfg_window), .go(go), .irq_en_we(irq_en_we),
      .irq_en_wdata(irq_en_wdata), .irq_clr(irq_clr), .busy(s_busy),
      .result(s_result), .irq_stat_n(s_stat_n), .irq(s_irq)
   );

   task automatic check(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   task automatic write_cfg(input int t, input int r, input int n);
      cfg_we = 1; cfg_tgt_sel = 3'(t); cfg_ref_sel = 3'(r); cfg_window = 16'(n);
      @(posedge clk); @(negedge clk);
      cfg_we = 0;
   endtask

   // One measurement: target tick every tper cycles, reference every rper.
   // noise drives every unselected tick bit high. meddle injects a config
   // write and a go pulse in the third cycle of the run.
   task automatic run_cal(input string req, input int t, input int r, input int n,
                          input int tper, input int rper, input bit noise, input bit meddle);
      longint exp = 0;
      int seen = 0;
      bit busy_ok = 1;
      write_cfg(t, r, n);
      go = 1; @(posedge clk); @(negedge clk); go = 0;
      for (int cyc = 0; cyc < 5000; cyc++) begin
         tgt_tick = noise ? 5'h1f : 5'h00;
         ref_tick = noise ? 6'h3f : 6'h00;
         tgt_tick[t] = ((cyc % tper) == tper - 1);
         ref_tick[r] = ((cyc % rper) == 0);
         if (meddle && cyc == 2) begin
            cfg_we = 1; cfg_window = 16'd1; cfg_ref_sel = 3'((r + 1) % 6);
            go = 1;
         end
         if (ref_tick[r]) exp++;
         if (tgt_tick[t]) seen++;
         if (busy !== 1'b1) busy_ok = 0;
         @(posedge clk); @(negedge clk);
         cfg_we = 0; go = 0;
         if (seen == n) break;
      end
      tgt_tick = '0; ref_tick = '0;
      check({req, " R3 busy held during run"}, busy_ok, 1);
      check({req, " R3 busy clears after last target"}, busy, 0);
      check({req, " R4 result"}, result, exp);
      check({req, " R5 saturating result"}, s_result, (exp > 63) ? 63 : exp);
      check({req, " R8 status pending"}, irq_stat_n, 0);
   endtask

   task automatic test_reset();
      check("R3 reset busy", busy, 0);
      check("R4 reset result", result, 0);
      check("R8 reset status", irq_stat_n, 1);
      check("R9 reset irq", irq, 0);
   endtask

   task automatic test_basic();
      run_cal("R1 R2 trim/fast", 3, 2, 5, 4, 1, 0, 0);
      run_cal("R1 R2 crystal/div", 2, 0, 3, 7, 2, 0, 0);
   endtask

   task automatic test_encodings();
      run_cal("R1 R2 lp/ext noise", 0, 5, 4, 3, 1, 1, 0);
      run_cal("R1 R2 gen/lp noise", 4, 1, 2, 5, 3, 1, 0);
      run_cal("R1 R2 fast/gen noise", 1, 4, 3, 2, 1, 1, 0);
      run_cal("R2 xtal ref", 3, 3, 2, 6, 2, 1, 0);
   endtask

   task automatic test_busy_writes();
      run_cal("R6 writes ignored", 3, 2, 6, 3, 1, 0, 1);
   endtask

   task automatic test_saturation();
      run_cal("R5 overrun", 2, 0, 3, 30, 1, 0, 0);
      check("R5 wide instance exact", result, 90);
   endtask

   task automatic test_zero_window();
      irq_clr = 1; @(posedge clk); @(negedge clk); irq_clr = 0;
      check("R8 cleared", irq_stat_n, 1);
      write_cfg(3, 2, 0);
      go = 1; @(posedge clk); @(negedge clk); go = 0;
      check("R7 zero busy", busy, 0);
      check("R7 zero result", result, 0);
      check("R7 zero pending", irq_stat_n, 0);
   endtask

   task automatic test_irq();
      check("R9 irq masked", irq, 0);
      irq_en_we = 1; irq_en_wdata = 1; @(posedge clk); @(negedge clk); irq_en_we = 0;
      check("R9 irq raised", irq, 1);
      irq_clr = 1; @(posedge clk); @(negedge clk); irq_clr = 0;
      check("R8 clear status", irq_stat_n, 1);
      check("R9 irq dropped", irq, 0);
      irq_clr = 1; go = 1; @(posedge clk); @(negedge clk); irq_clr = 0; go = 0;
      check("R8 completion beats clear", irq_stat_n, 0);
      check("R9 irq after set", irq, 1);
      irq_en_we = 1; irq_en_wdata = 0; @(posedge clk); @(negedge clk); irq_en_we = 0;
      check("R9 irq disabled", irq, 0);
   endtask

   initial begin
      #100000;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1;
      @(negedge clk);
      test_basic();
      test_encodings();
      test_busy_writes();
      test_saturation();
      test_zero_window();
      test_irq();
      finish_run();
   end
endmodule